// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block carries out the repeating byte-copy, byte-search and block port-transfer operations of an 8-bit processor core. A one-cycle start pulse hands it an operation kind, a direction bit, a repeat bit, the current pointer pair values (HL and DE), the 16-bit counter (BC), the accumulator byte and the incoming Z and P/V flags. The block then walks memory one element per iteration. Each iteration uses a byte-wide memory port and a byte-wide port bus with a 16-bit address, and both use a request/acknowledge handshake. At the end of each iteration the block updates its pointers, counter and flags.

The operation kind selects how an iteration runs and how the run ends. Copy and search count down the full 16-bit BC, and a repeating search also stops at the first byte equal to the accumulator. Port input and port output count down only the upper byte B, and they drive the whole BC value as the port address. When the last iteration completes, the block raises a one-cycle done pulse. The updated register and flag values then stay on the outputs until the next start, so the core can write them back.

Top module: `blk_xfer_seq`

## Requirements
- R1: The 2-bit `op_kind` selects the operation: 2'b00 copy, 2'b01 search, 2'b10 port input, 2'b11 port output. A copy iteration first reads memory at HL, then writes that byte to memory at DE.
- R2: With `dir_dn` = 0, each iteration increments HL by one, and a copy also increments DE. With `dir_dn` = 1, both decrement by one instead. Pointers wrap modulo 2^16.
- R3: Copy and search decrement the 16-bit BC once per iteration. After each iteration P/V is 1 exactly when the new BC is non-zero.
- R4: A search iteration reads memory at HL and sets Z to 1 exactly when the byte equals the accumulator. It performs no memory write. A copy leaves Z at its input value.
- R5: With `repeat_en` = 1, copy and search keep iterating until BC reaches zero. A repeating search also stops after the iteration that finds a match. With `repeat_en` = 0, exactly one iteration runs.
- R6: Port input reads from port address BC. Port output writes to port address {B-1, C}, because B is decremented before the port access.
- R7: Port input writes the received byte to memory at HL. Port output reads memory at HL and sends that byte to the port. Both decrement only B, leave C unchanged, and repeat until B reaches zero when `repeat_en` = 1.
- R8: After a port input or port output iteration, Z is 1 exactly when the new B is zero, and P/V keeps its input value.
- R9: A starting counter of zero wraps on the first decrement. A repeating port transfer with B = 0 runs 256 iterations. A single copy with BC = 0 leaves BC = 16'hFFFF and P/V = 1.
- R10: Only one of `mem_req` and `io_req` is high at a time. Once raised, a request holds its address, write enable and write data unchanged until the cycle in which its acknowledge is seen.
- R11: `busy` is high from the cycle after start until `done`. `done` is a one-cycle pulse that comes with the final register values. Those values hold until the next start, and a start received while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start pulse, taken only when idle |
| op_kind | input | 2 | Operation select (see R1) |
| dir_dn | input | 1 | 1 = pointers decrement, 0 = increment |
| repeat_en | input | 1 | 1 = iterate until the end condition |
| hl_in | input | 16 | Source/destination pointer at start |
| de_in | input | 16 | Copy destination pointer at start |
| bc_in | input | 16 | Counter / port address at start |
| acc_in | input | 8 | Accumulator for search compare |
| z_in | input | 1 | Z flag at start |
| pv_in | input | 1 | P/V flag at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 8 | Memory read data |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | Port write (1) or read (0) |
| io_addr | output | 16 | 16-bit port address |
| io_wdata | output | 8 | Port write data |
| io_ack | input | 1 | Port acknowledge, read data valid |
| io_rdata | input | 8 | Port read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | 16 | Current HL value |
| de_out | output | 16 | Current DE value |
| bc_out | output | 16 | Current BC value |
| z_out | output | 1 | Current Z flag |
| pv_out | output | 1 | Current P/V flag |

## Verification
The hardest cases to reach are the ones where the end condition depends on data rather than on the counter. A repeating search has to stop on a mid-block match. A copy whose destination overlaps its source has to re-read bytes it has just written. The bench reaches both by seeding memory from an address formula, setting the accumulator to the byte a known number of places ahead, and placing DE one above HL. Handshake holding is stressed by a responder that varies its acknowledge delay from zero to two cycles. The 256-iteration zero-B case and a start pulse arriving while busy are driven directly.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    OP_COPY = 2'b00,
    OP_SCAN = 2'b01,
    OP_PIN  = 2'b10,
    OP_POUT = 2'b11
  } xop_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MRD  = 3'd1,
    S_MWR  = 3'd2,
    S_IORD = 3'd3,
    S_IOWR = 3'd4,
    S_UPD  = 3'd5
  } st_e;

  function automatic st_e entry_state(xop_e op);
    return (op == OP_PIN) ? S_IORD : S_MRD;
  endfunction

endpackage

// File: rtl/blk_xfer_rst_sync.sv
module blk_xfer_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/blk_xfer_step.sv
module blk_xfer_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         dn,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res = dn ? (val - ONE) : (val + ONE);
  end
endmodule

// File: rtl/blk_xfer_fsm.sv
module blk_xfer_fsm
  import blk_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  xop_e op_i,
  input  logic rpt_i,
  input  logic mem_ack,
  input  logic io_ack,
  input  logic fin,
  output st_e  st,
  output xop_e op_q,
  output logic go,
  output logic upd,
  output logic rd_cap,
  output logic busy,
  output logic done,
  output logic mem_req,
  output logic mem_we,
  output logic io_req,
  output logic io_we
);
  st_e  st_nx;
  logic done_nx;
  logic rpt_q;

  always_comb begin
    st_nx   = st;
    done_nx = 1'b0;
    case (st)
      S_IDLE: if (start) st_nx = entry_state(op_i);
      S_MRD: begin
        if (mem_ack) begin
          case (op_q)
            OP_COPY: st_nx = S_MWR;
            OP_SCAN: st_nx = S_UPD;
            default: st_nx = S_IOWR;
          endcase
        end
      end
      S_MWR:  if (mem_ack) st_nx = S_UPD;
      S_IORD: if (io_ack)  st_nx = S_MWR;
      S_IOWR: if (io_ack)  st_nx = S_UPD;
      S_UPD: begin
        if (rpt_q && !fin) begin
          st_nx = entry_state(op_q);
        end else begin
          st_nx   = S_IDLE;
          done_nx = 1'b1;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= done_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_COPY;
      rpt_q <= 1'b0;
    end else if (go) begin
      op_q  <= op_i;
      rpt_q <= rpt_i;
    end
  end

  always_comb begin
    go      = (st == S_IDLE) && start;
    upd     = (st == S_UPD);
    rd_cap  = ((st == S_MRD) && mem_ack) || ((st == S_IORD) && io_ack);
    busy    = (st != S_IDLE);
    mem_req = (st == S_MRD) || (st == S_MWR);
    mem_we  = (st == S_MWR);
    io_req  = (st == S_IORD) || (st == S_IOWR);
    io_we   = (st == S_IOWR);
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && io_req));
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));

endmodule

// File: rtl/blk_xfer_dpath.sv
module blk_xfer_dpath
  import blk_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          upd,
  input  logic          rd_cap,
  input  st_e           st,
  input  xop_e          op_q,
  input  logic          dir_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] de_i,
  input  logic [AW-1:0] bc_i,
  input  logic [DW-1:0] a_i,
  input  logic          z_i,
  input  logic          pv_i,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] io_rdata,
  output logic          fin,
  output logic [AW-1:0] hl_o,
  output logic [AW-1:0] de_o,
  output logic [AW-1:0] bc_o,
  output logic          z_o,
  output logic          pv_o,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] io_addr,
  output logic [DW-1:0] io_wdata
);
  localparam int LO_W = AW - DW;
  localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ONE_D = {{(DW-1){1'b0}}, 1'b1};

  logic [AW-1:0] hl_q, de_q, bc_q;
  logic [AW-1:0] hl_nx, de_nx, bc_nx;
  logic [AW-1:0] hl_step, de_step, bc_dec, bc_io;
  logic [DW-1:0] a_q, byte_q, b_dec;
  logic          dn_q, z_q, pv_q, z_nx, pv_nx, match, wide_cnt;

  blk_xfer_step #(.W(AW)) u_hl_step (.val(hl_q), .dn(dn_q), .res(hl_step));
  blk_xfer_step #(.W(AW)) u_de_step (.val(de_q), .dn(dn_q), .res(de_step));

  always_comb begin
    bc_dec   = bc_q - ONE_A;
    b_dec    = bc_q[AW-1:LO_W] - ONE_D;
    bc_io    = {b_dec, bc_q[LO_W-1:0]};
    match    = (a_q == byte_q);
    wide_cnt = (op_q == OP_COPY) || (op_q == OP_SCAN);
    case (op_q)
      OP_COPY: fin = (bc_dec == '0);
      OP_SCAN: fin = (bc_dec == '0) || match;
      default: fin = (b_dec == '0);
    endcase
  end

  always_comb begin
    hl_nx = hl_q;
    de_nx = de_q;
    bc_nx = bc_q;
    z_nx  = z_q;
    pv_nx = pv_q;
    if (go) begin
      hl_nx = hl_i;
      de_nx = de_i;
      bc_nx = bc_i;
      z_nx  = z_i;
      pv_nx = pv_i;
    end else if (upd) begin
      hl_nx = hl_step;
      if (op_q == OP_COPY) de_nx = de_step;
      bc_nx = wide_cnt ? bc_dec : bc_io;
      if (wide_cnt) pv_nx = (bc_dec != '0);
      case (op_q)
        OP_COPY: z_nx = z_q;
        OP_SCAN: z_nx = match;
        default: z_nx = (b_dec == '0);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q <= '0;
      de_q <= '0;
      bc_q <= '0;
      z_q  <= 1'b0;
      pv_q <= 1'b0;
    end else if (go || upd) begin
      hl_q <= hl_nx;
      de_q <= de_nx;
      bc_q <= bc_nx;
      z_q  <= z_nx;
      pv_q <= pv_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      dn_q <= 1'b0;
    end else if (go) begin
      a_q  <= a_i;
      dn_q <= dir_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (rd_cap) begin
      byte_q <= (st == S_IORD) ? io_rdata : mem_rdata;
    end
  end

  always_comb begin
    mem_addr  = ((st == S_MWR) && (op_q == OP_COPY)) ? de_q : hl_q;
    io_addr   = (op_q == OP_POUT) ? bc_io : bc_q;
    mem_wdata = byte_q;
    io_wdata  = byte_q;
    hl_o      = hl_q;
    de_o      = de_q;
    bc_o      = bc_q;
    z_o       = z_q;
    pv_o      = pv_q;
  end

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !go) |=> $stable(hl_q) && $stable(de_q) && $stable(bc_q)
                              && $stable(z_q) && $stable(pv_q));
  p_bc_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && wide_cnt) |=> (bc_q == $past(bc_q) - ONE_A));
  p_c_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wide_cnt) |=> (bc_q[LO_W-1:0] == $past(bc_q[LO_W-1:0])) && $stable(pv_q));
  p_hl_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (hl_q == ($past(dn_q) ? $past(hl_q) - ONE_A : $past(hl_q) + ONE_A)));

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_kind,
  input  logic              dir_dn,
  input  logic              repeat_en,
  input  logic [ADDR_W-1:0] hl_in,
  input  logic [ADDR_W-1:0] de_in,
  input  logic [ADDR_W-1:0] bc_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              z_in,
  input  logic              pv_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              io_req,
  output logic              io_we,
  output logic [ADDR_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic              io_ack,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] hl_out,
  output logic [ADDR_W-1:0] de_out,
  output logic [ADDR_W-1:0] bc_out,
  output logic              z_out,
  output logic              pv_out
);
  logic srst_n;
  logic go, upd, rd_cap, fin;
  st_e  st;
  xop_e op_q;

  blk_xfer_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  blk_xfer_fsm u_fsm (
    .clk(clk), .rst_n(srst_n), .start(start), .op_i(xop_e'(op_kind)),
    .rpt_i(repeat_en), .mem_ack(mem_ack), .io_ack(io_ack), .fin(fin),
    .st(st), .op_q(op_q), .go(go), .upd(upd), .rd_cap(rd_cap),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .io_req(io_req), .io_we(io_we)
  );

  blk_xfer_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
    .clk(clk), .rst_n(srst_n), .go(go), .upd(upd), .rd_cap(rd_cap),
    .st(st), .op_q(op_q), .dir_i(dir_dn), .hl_i(hl_in), .de_i(de_in),
    .bc_i(bc_in), .a_i(acc_in), .z_i(z_in), .pv_i(pv_in),
    .mem_rdata(mem_rdata), .io_rdata(io_rdata), .fin(fin),
    .hl_o(hl_out), .de_o(de_out), .bc_o(bc_out), .z_o(z_out), .pv_o(pv_out),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .io_addr(io_addr), .io_wdata(io_wdata)
  );

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));
  p_io_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (io_req && !io_ack) |=> io_req && $stable(io_addr) && $stable(io_we)
                            && $stable(io_wdata));

endmodule

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op_kind;
  logic        dir_dn, repeat_en, z_in, pv_in;
  logic [15:0] hl_in, de_in, bc_in;
  logic [7:0]  acc_in;
  logic        mem_req, mem_we, mem_ack, io_req, io_we, io_ack;
  logic [15:0] mem_addr, io_addr;
  logic [7:0]  mem_wdata, mem_rdata, io_wdata, io_rdata;
  logic        busy, done, z_out, pv_out;
  logic [15:0] hl_out, de_out, bc_out;

  always #2 clk = ~clk;

  blk_xfer_seq uut (.*);

  typedef struct {
    bit          io;
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
  } txn_t;

  txn_t       exp_q[$];
  logic [7:0] dmem[int];
  logic [7:0] mmod[int];
  int         n_tests = 0;
  int         n_fail  = 0;
  int         cycles  = 0;
  int         mwait = 0, mdly = 0, iwait = 0, idly = 0;
  logic [31:0] seed = 32'h1234_5678;
  string      cur_tag = "R10";

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return 8'((a * 37) + (a >> 8) + 8'h11);
  endfunction

  function automatic logic [7:0] fio(input logic [15:0] a);
    return 8'(a[7:0] + a[15:8] * 3 + 8'h5A);
  endfunction

  function automatic logic [7:0] d_rd(input logic [15:0] a);
    return dmem.exists(int'(a)) ? dmem[int'(a)] : fmem(a);
  endfunction

  function automatic logic [7:0] m_rd(input logic [15:0] a);
    return mmod.exists(int'(a)) ? mmod[int'(a)] : fmem(a);
  endfunction

  function automatic int next_dly();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[17:16]) % 3;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit io, input bit we, input logic [15:0] a, input logic [7:0] d);
    txn_t t;
    t.io = io; t.we = we; t.addr = a; t.data = d;
    exp_q.push_back(t);
  endtask

  task automatic see_txn(input bit io, input bit we, input logic [15:0] a, input logic [7:0] d);
    txn_t t;
    if (exp_q.size() == 0) begin
      chk(cur_tag, "unexpected transfer", int'(a), -1);
      return;
    end
    t = exp_q.pop_front();
    chk(cur_tag, "port kind (R1/R6)", int'(io), int'(t.io));
    chk(cur_tag, "write enable (R1/R7)", int'(we), int'(t.we));
    chk(cur_tag, "address (R2/R6)", int'(a), int'(t.addr));
    if (t.we) chk(cur_tag, "write data (R7)", int'(d), int'(t.data));
  endtask

  // responders: acknowledge after 0..2 idle cycles, driven at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10", "single port request", int'(mem_req && io_req), 0);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mwait >= mdly) begin
          see_txn(1'b0, mem_we, mem_addr, mem_wdata);
          mem_rdata = d_rd(mem_addr);
          if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
          mem_ack = 1'b1;
          mwait = 0;
          mdly = next_dly();
        end else mwait++;
      end
      if (io_ack) io_ack = 1'b0;
      else if (io_req) begin
        if (iwait >= idly) begin
          see_txn(1'b1, io_we, io_addr, io_wdata);
          io_rdata = fio(io_addr);
          io_ack = 1'b1;
          iwait = 0;
          idly = next_dly();
        end else iwait++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_op(input string tag, input int op, input bit dn, input bit rp,
                        input logic [15:0] hl, input logic [15:0] de, input logic [15:0] bc,
                        input logic [7:0] a, input bit zi, input bit pvi, input bit poke);
    logic [15:0] h, d, c;
    logic [7:0]  v;
    logic        z, p;
    bit          fin;
    int          wait_n;
    h = hl; d = de; c = bc; z = zi; p = pvi;
    do begin
      case (op)
        0: begin
          v = m_rd(h); push(0, 0, h, 8'h00); push(0, 1, d, v); mmod[int'(d)] = v;
          h = dn ? h - 16'd1 : h + 16'd1; d = dn ? d - 16'd1 : d + 16'd1;
          c = c - 16'd1; p = (c != 0); fin = (c == 0);
        end
        1: begin
          v = m_rd(h); push(0, 0, h, 8'h00);
          h = dn ? h - 16'd1 : h + 16'd1;
          c = c - 16'd1; p = (c != 0); z = (a == v); fin = (c == 0) || z;
        end
        2: begin
          v = fio(c); push(1, 0, c, 8'h00); push(0, 1, h, v); mmod[int'(h)] = v;
          h = dn ? h - 16'd1 : h + 16'd1;
          c[15:8] = c[15:8] - 8'd1; z = (c[15:8] == 0); fin = z;
        end
        default: begin
          c[15:8] = c[15:8] - 8'd1;
          v = m_rd(h); push(0, 0, h, 8'h00); push(1, 1, c, v);
          h = dn ? h - 16'd1 : h + 16'd1;
          z = (c[15:8] == 0); fin = z;
        end
      endcase
    end while (rp && !fin);

    cur_tag = tag;
    @(negedge clk);
    op_kind = 2'(op); dir_dn = dn; repeat_en = rp;
    hl_in = hl; de_in = de; bc_in = bc; acc_in = a; z_in = zi; pv_in = pvi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11", {tag, " busy after start"}, int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      op_kind = 2'b11; hl_in = 16'hFFFF; de_in = 16'h0; bc_in = 16'h0100;
      dir_dn = ~dn; repeat_en = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(tag, "done seen (R11)", int'(done), 1);
    chk(tag, "final HL", int'(hl_out), int'(h));
    chk(tag, "final DE", int'(de_out), int'(d));
    chk(tag, "final BC", int'(bc_out), int'(c));
    chk(tag, "final Z", int'(z_out), int'(z));
    chk(tag, "final P/V", int'(pv_out), int'(p));
    chk(tag, "all transfers made", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk("R11", {tag, " done is one cycle"}, int'(done), 0);
    chk("R11", {tag, " idle after done"}, int'(busy), 0);
    repeat (2) @(negedge clk);
    chk("R11", {tag, " HL held"}, int'(hl_out), int'(h));
    chk("R11", {tag, " BC held"}, int'(bc_out), int'(c));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op_kind = 2'b00; dir_dn = 1'b0; repeat_en = 1'b0;
    hl_in = '0; de_in = '0; bc_in = '0; acc_in = '0; z_in = 1'b0; pv_in = 1'b0;
    mem_ack = 1'b0; io_ack = 1'b0; mem_rdata = '0; io_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", int'(busy), 0);
    chk("R11", "reset done", int'(done), 0);
    chk("R10", "reset mem_req", int'(mem_req), 0);
    chk("R10", "reset io_req", int'(io_req), 0);

    run_op("R1 copy up repeat",       0, 0, 1, 16'h1000, 16'h2000, 16'd5, 8'h00, 1, 0, 0);
    run_op("R2 copy down repeat",     0, 1, 1, 16'h3001, 16'h4100, 16'd3, 8'h00, 0, 1, 0);
    run_op("R3 copy single last",     0, 0, 0, 16'h0500, 16'h0600, 16'd1, 8'h00, 1, 1, 0);
    run_op("R9 copy single zero",     0, 1, 0, 16'h0000, 16'h0700, 16'd0, 8'h00, 0, 0, 0);
    run_op("R1 copy overlap",         0, 0, 1, 16'h5000, 16'h5001, 16'd4, 8'h00, 0, 0, 0);
    run_op("R5 search early match",   1, 0, 1, 16'h6000, 16'h0,    16'd8, fmem(16'h6002), 0, 0, 0);
    run_op("R5 search no match",      1, 1, 1, 16'h6105, 16'h0,    16'd4, fmem(16'h6200), 1, 0, 0);
    run_op("R4 search single",        1, 0, 0, 16'h6300, 16'h0,    16'd2, fmem(16'h6300), 0, 0, 0);
    run_op("R7 input down repeat",    2, 1, 1, 16'h7010, 16'h0,    16'h0342, 8'h00, 0, 1, 0);
    run_op("R6 output up repeat",     3, 0, 1, 16'h7100, 16'h0,    16'h0499, 8'h00, 0, 0, 0);
    run_op("R8 output single last",   3, 0, 0, 16'h7200, 16'h0,    16'h0107, 8'h00, 0, 1, 0);
    run_op("R8 input single",         2, 0, 0, 16'h7300, 16'h0,    16'h0520, 8'h00, 1, 0, 0);
    run_op("R9 output zero B",        3, 0, 1, 16'h8000, 16'h0,    16'h0033, 8'h00, 0, 1, 0);
    run_op("R9 input zero B",         2, 1, 1, 16'h9000, 16'h0,    16'h0044, 8'h00, 0, 0, 0);
    run_op("R11 start while busy",    0, 0, 1, 16'hA000, 16'hB000, 16'd5, 8'h00, 0, 0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule